// File: doc/BRIEF.md
# Direct-Mode Interrupt Delivery Controller

This block gathers a set of wired interrupt sources and sends each one to one of several hart delivery contexts. Each context drives one external-interrupt line. Every source can be switched on or off, and it works either as a rising-edge source or as a level source. Software gives each source a destination context index and a priority. Lower priority numbers are more urgent. A priority written as 0 is stored as 1.

Each context has four registers:
- a delivery-enable bit;
- a threshold, which passes only priorities strictly below it (0 turns filtering off);
- a read-only top-pending word;
- a claim word. Reading it returns the best eligible source and clears that source's pending bit in the same access.

A handler reads the claim word repeatedly until it returns zero.

All registers sit on a simple single-request memory-mapped bus. A small state machine serves the bus, with three states:
- `ST_IDLE` waits for a request.
- `ST_RD_ACK` returns read data.
- `ST_WR_ACK` acknowledges a write.

The transitions are: `ST_IDLE`→`ST_RD_ACK` on a read request, `ST_IDLE`→`ST_WR_ACK` on a write request, and either ack state→`ST_IDLE` unconditionally after one cycle.

Top module: `irq_direct_ctrl`

## Requirements
- R1: After reset the following hold: every context has delivery off and threshold 0; every target register reads 0x00000001 (index 0, priority 1); every source is disabled; `irq_o` is 0; every claim word reads 0.
- R2: The target register of source s (s = 1..NUM_SRC) is at 0x3000 + (s−1)×4. It holds the destination context index in bits 31:18 and the priority in bits 7:0. A priority written as 0 reads back and acts as 1.
- R3: A write to the target address of a source number above NUM_SRC is ignored and does not alter any implemented source. A read of that address returns 0.
- R4: An enabled edge source becomes pending only on a 0→1 transition of its input. An input held high yields exactly one claim.
- R5: For an enabled level source, pending follows the input one cycle later. A claim while the input is still high leaves the source pending, so the next claim returns it again.
- R6: The source config word is at 0x1000 + (s−1)×4. Bit 0 enables the source and bit 1 selects edge mode (1) or level mode (0). A disabled source is never pending, and pulses on its input have no effect.
- R7: The claim and top-pending words carry the source ID in bits 25:16 and its priority in bits 7:0. The eligible source with the lowest priority number wins, and a tie goes to the lower source number. Reading top-pending returns the same word as a claim but does not clear anything.
- R8: A claim read clears the returned edge source's pending bit. When no source is eligible, the claim word reads 0.
- R9: A source is eligible for a context only if its priority is strictly less than that context's threshold, or if the threshold is 0.
- R10: `irq_o[c]` is high exactly when context c has delivery enabled and at least one eligible source pending. Top-pending and claim do not depend on delivery enable.
- R11: A source whose target index names no existing context is offered to no context.
- R12: The window of context c is at 0x4000 + c×0x20. It holds delivery enable at +0x00 (bit 0), threshold at +0x04, top-pending at +0x18 and claim at +0x1C. A one-cycle `bus_sel` pulse is acknowledged on the next cycle, with read data valid alongside `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Source inputs; bit k is source k+1 |
| bus_sel | input | 1 | One-cycle request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Request acknowledge, one cycle after bus_sel |
| irq_o | output | NUM_CTX | External-interrupt line per context |

## Verification
The bench uses eight sources spread over two contexts, with priorities chosen so that each context holds a tie.

It drives the following input patterns:
- A single-source sweep, which shows routing and that the claim clears pending.
- All sources pulsed together and then drained, which shows the claim order, including the tie-break by source number.
- A threshold swept from 0 upwards, which separates strict from non-strict filtering.
- A held-high edge input next to a held-high level input, which separates the two source modes.

Further runs cover delivery disabled, a disabled source, an out-of-range target index and an unimplemented target address. Together these confirm that each of them leaves the outputs and the readable state unchanged.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_ACK = 2'd1,
        ST_WR_ACK = 2'd2
    } bus_state_e;

    // Claim / top-pending word layout
    localparam int ID_LSB   = 16;
    localparam int ID_W     = 10;

    // Target word layout
    localparam int HIDX_LSB = 18;
    localparam int HIDX_W   = 14;

    // Source config bits
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_EDGE_BIT = 1;

    // Offsets inside a context window
    localparam int OFF_DELIVER = 'h00;
    localparam int OFF_THRESH  = 'h04;
    localparam int OFF_TOP     = 'h18;
    localparam int OFF_CLAIM   = 'h1C;

endpackage

// File: rtl/irqd_src_cell.sv
module irqd_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic en,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic rise;

    assign rise = src_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= src_i;
            if (!en)
                pend <= 1'b0;
            else if (edge_mode)
                pend <= rise | (pend & ~clr);   // a new edge beats a claim
            else
                pend <= src_i;                  // level: follow the wire
        end
    end
endmodule

// File: rtl/irqd_ctx_pick.sv
module irqd_ctx_pick #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 8,
    parameter int HIDX_W  = 14,
    parameter int ID_W    = 10,
    parameter int CTX_ID  = 0
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0][HIDX_W-1:0] tgt_idx,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] tgt_prio,
    input  logic [PRIO_W-1:0]              thr,
    output logic [ID_W-1:0]                best_id,
    output logic [PRIO_W-1:0]              best_prio
);
    logic              found;
    logic [PRIO_W-1:0] bp;
    logic [ID_W-1:0]   bid;
    logic              elig;

    always_comb begin
        found = 1'b0;
        bp    = '1;
        bid   = '0;
        elig  = 1'b0;
        // ascending scan with strict compare keeps the lower ID on ties
        for (int k = 0; k < NUM_SRC; k++) begin
            elig = pend[k]
                && (tgt_idx[k] == HIDX_W'(CTX_ID))
                && ((thr == '0) || (tgt_prio[k] < thr));
            if (elig && (!found || (tgt_prio[k] < bp))) begin
                found = 1'b1;
                bp    = tgt_prio[k];
                bid   = ID_W'(k + 1);
            end
        end
        best_id   = bid;
        best_prio = found ? bp : '0;
    end
endmodule

// File: rtl/irq_direct_ctrl.sv
module irq_direct_ctrl
    import irqd_pkg::*;
#(
    parameter int          NUM_SRC  = 8,
    parameter int          NUM_CTX  = 2,
    parameter int          PRIO_W   = 8,
    parameter int          ADDR_W   = 16,
    parameter int unsigned CFG_BASE = 'h1000,
    parameter int unsigned TGT_BASE = 'h3000,
    parameter int unsigned CTX_BASE = 'h4000,
    parameter int          CTX_SH   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_ack,
    output logic [NUM_CTX-1:0] irq_o
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] CFG_LO  = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] TGT_LO  = ADDR_W'(TGT_BASE);
    localparam logic [ADDR_W-1:0] CTX_LO  = ADDR_W'(CTX_BASE);
    localparam logic [ADDR_W-1:0] SRC_SPAN = ADDR_W'(NUM_SRC * 4);
    localparam logic [ADDR_W-1:0] CTX_SPAN = ADDR_W'(NUM_CTX << CTX_SH);

    // ---------------- state ----------------
    bus_state_e state_q, state_d;

    logic [NUM_SRC-1:0]             cfg_en, cfg_edge, pend, clr;
    logic [NUM_SRC-1:0][HIDX_W-1:0] tgt_idx;
    logic [NUM_SRC-1:0][PRIO_W-1:0] tgt_prio;
    logic [NUM_CTX-1:0]             del_en;
    logic [NUM_CTX-1:0][PRIO_W-1:0] thr;
    logic [NUM_CTX-1:0][ID_W-1:0]   best_id;
    logic [NUM_CTX-1:0][PRIO_W-1:0] best_prio;
    logic [NUM_CTX-1:0][31:0]       top_word;
    logic [31:0]                    rd_val, rdata_q;

    // ---------------- decode ----------------
    logic [ADDR_W-1:0] cfg_off, tgt_off, ctx_off, ctx_num;
    logic [WORD_W-1:0] cfg_word, tgt_word;
    logic [CTX_SH-1:0] reg_off;
    logic              cfg_hit, tgt_hit, ctx_hit;
    logic              rd_fire, wr_fire;
    logic [PRIO_W-1:0] wprio;
    logic              unused_bits;

    assign cfg_off  = bus_addr - CFG_LO;
    assign tgt_off  = bus_addr - TGT_LO;
    assign ctx_off  = bus_addr - CTX_LO;
    assign cfg_word = cfg_off[ADDR_W-1:2];
    assign tgt_word = tgt_off[ADDR_W-1:2];
    assign ctx_num  = ctx_off >> CTX_SH;
    assign reg_off  = ctx_off[CTX_SH-1:0];
    assign cfg_hit  = (bus_addr >= CFG_LO) && (cfg_off < SRC_SPAN);
    assign tgt_hit  = (bus_addr >= TGT_LO) && (tgt_off < SRC_SPAN);
    assign ctx_hit  = (bus_addr >= CTX_LO) && (ctx_off < CTX_SPAN);
    assign rd_fire  = (state_q == ST_IDLE) && bus_sel && !bus_wr;
    assign wr_fire  = (state_q == ST_IDLE) && bus_sel &&  bus_wr;
    assign wprio    = (bus_wdata[PRIO_W-1:0] == '0) ? PRIO_W'(1)
                                                     : bus_wdata[PRIO_W-1:0];
    assign unused_bits = ^{bus_wdata[HIDX_LSB-1:PRIO_W], cfg_off[1:0], tgt_off[1:0]};

    // ---------------- bus state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (bus_sel) state_d = bus_wr ? ST_WR_ACK : ST_RD_ACK;
            ST_RD_ACK: state_d = ST_IDLE;
            ST_WR_ACK: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_ack   = 1'b0;
        bus_rdata = '0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RD_ACK: begin bus_ack = 1'b1; bus_rdata = rdata_q; end
            ST_WR_ACK: bus_ack = 1'b1;
            default:   ;
        endcase
    end

    // ---------------- per-source pending ----------------
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        irqd_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_i    (src_i[k]),
            .en       (cfg_en[k]),
            .edge_mode(cfg_edge[k]),
            .clr      (clr[k]),
            .pend     (pend[k])
        );
    end

    // ---------------- per-context selection ----------------
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        irqd_ctx_pick #(
            .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .HIDX_W(HIDX_W),
            .ID_W(ID_W), .CTX_ID(c)
        ) u_pick (
            .pend     (pend),
            .tgt_idx  (tgt_idx),
            .tgt_prio (tgt_prio),
            .thr      (thr[c]),
            .best_id  (best_id[c]),
            .best_prio(best_prio[c])
        );

        always_comb begin
            top_word[c] = '0;
            top_word[c][ID_LSB +: ID_W]  = best_id[c];
            top_word[c][PRIO_W-1:0]      = best_prio[c];
        end

        assign irq_o[c] = del_en[c] && (best_id[c] != '0);
    end

    // ---------------- claim clear ----------------
    always_comb begin
        clr = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (rd_fire && ctx_hit && (ctx_num == ADDR_W'(c))
                && (reg_off == CTX_SH'(OFF_CLAIM))) begin
                for (int k = 0; k < NUM_SRC; k++)
                    if (best_id[c] == ID_W'(k + 1)) clr[k] = 1'b1;
            end
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (cfg_hit && (cfg_word == WORD_W'(k))) begin
                rd_val[CFG_EN_BIT]   = cfg_en[k];
                rd_val[CFG_EDGE_BIT] = cfg_edge[k];
            end
            if (tgt_hit && (tgt_word == WORD_W'(k))) begin
                rd_val[HIDX_LSB +: HIDX_W] = tgt_idx[k];
                rd_val[PRIO_W-1:0]         = tgt_prio[k];
            end
        end
        for (int c = 0; c < NUM_CTX; c++) begin
            if (ctx_hit && (ctx_num == ADDR_W'(c))) begin
                if (reg_off == CTX_SH'(OFF_DELIVER)) rd_val[0] = del_en[c];
                if (reg_off == CTX_SH'(OFF_THRESH))  rd_val[PRIO_W-1:0] = thr[c];
                if ((reg_off == CTX_SH'(OFF_TOP)) || (reg_off == CTX_SH'(OFF_CLAIM)))
                    rd_val = top_word[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_fire) rdata_q <= rd_val;
    end

    // ---------------- register writes ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en   <= '0;
            cfg_edge <= '0;
            for (int k = 0; k < NUM_SRC; k++) begin
                tgt_idx[k]  <= '0;
                tgt_prio[k] <= PRIO_W'(1);
            end
            del_en <= '0;
            thr    <= '0;
        end else if (wr_fire) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                if (cfg_hit && (cfg_word == WORD_W'(k))) begin
                    cfg_en[k]   <= bus_wdata[CFG_EN_BIT];
                    cfg_edge[k] <= bus_wdata[CFG_EDGE_BIT];
                end
                if (tgt_hit && (tgt_word == WORD_W'(k))) begin
                    tgt_idx[k]  <= bus_wdata[HIDX_LSB +: HIDX_W];
                    tgt_prio[k] <= wprio;
                end
            end
            for (int c = 0; c < NUM_CTX; c++) begin
                if (ctx_hit && (ctx_num == ADDR_W'(c))) begin
                    if (reg_off == CTX_SH'(OFF_DELIVER)) del_en[c] <= bus_wdata[0];
                    if (reg_off == CTX_SH'(OFF_THRESH))  thr[c]    <= bus_wdata[PRIO_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/irq_direct_ctrl_chk.sv
module irq_direct_ctrl_chk
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_SRC-1:0]             src_i,
    input logic [NUM_SRC-1:0]             cfg_en,
    input logic [NUM_SRC-1:0]             cfg_edge,
    input logic [NUM_SRC-1:0]             pend,
    input logic [NUM_SRC-1:0]             clr,
    input logic [NUM_CTX-1:0][PRIO_W-1:0] thr,
    input logic [NUM_CTX-1:0][ID_W-1:0]   best_id,
    input logic [NUM_CTX-1:0][PRIO_W-1:0] best_prio,
    input logic                           bus_sel,
    input logic                           bus_ack
);
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_ack) |=> bus_ack);                       // R12
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);                                    // R12

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_s
        AST_OFF_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_en[k] |=> !pend[k]);                             // R6
        AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_en[k] && !cfg_edge[k]) |=> (pend[k] == $past(src_i[k])));   // R5
        AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && cfg_en[k] && cfg_edge[k] && !src_i[k]) |=> !pend[k]); // R8
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_c
        AST_STRICT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
            ((best_id[c] != '0) && (thr[c] != '0)) |-> (best_prio[c] < thr[c]));  // R9
        AST_PRIO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (best_id[c] != '0) |-> (best_prio[c] != '0));        // R2
    end
endmodule

bind irq_direct_ctrl irq_direct_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .cfg_en   (cfg_en),
    .cfg_edge (cfg_edge),
    .pend     (pend),
    .clr      (clr),
    .thr      (thr),
    .best_id  (best_id),
    .best_prio(best_prio),
    .bus_sel  (bus_sel),
    .bus_ack  (bus_ack)
);

// File: tb/irq_direct_ctrl_bench.sv
module irq_direct_ctrl_bench;
    localparam int NS = 8;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_ack;
    logic [NC-1:0] irq_o;

    always #4 clk = ~clk;   // 125 MHz

    irq_direct_ctrl u_irq_direct_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .irq_o(irq_o)
    );

    int total = 0, bad = 0;
    bit done = 0;

    // bench-side model
    bit m_en[1:NS], m_edge[1:NS], m_pend[1:NS];
    int m_idx[1:NS], m_prio[1:NS];
    int m_thr[0:NC-1];

    function automatic int cfg_a(int s); return 'h1000 + (s - 1) * 4; endfunction
    function automatic int tgt_a(int s); return 'h3000 + (s - 1) * 4; endfunction
    function automatic int ctx_a(int c, int off); return 'h4000 + c * 'h20 + off; endfunction

    function automatic int exp_top(int c);
        int bi = 0, bp = 0;
        for (int s = 1; s <= NS; s++) begin
            bit p = m_edge[s] ? m_pend[s] : src[s-1];
            if (m_en[s] && p && m_idx[s] == c &&
                (m_thr[c] == 0 || m_prio[s] < m_thr[c]) &&
                (bi == 0 || m_prio[s] < bp)) begin
                bi = s; bp = m_prio[s];
            end
        end
        return (bi << 16) | bp;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a[15:0]; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a[15:0];
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic set_cfg(input int s, input bit en, input bit edg);
        wr(cfg_a(s), {30'b0, edg, en});
        m_en[s] = en; m_edge[s] = edg;
        if (!en) m_pend[s] = 0;
    endtask

    task automatic set_tgt(input int s, input int idx, input int pr);
        wr(tgt_a(s), (idx << 18) | pr);
        m_idx[s] = idx; m_prio[s] = (pr == 0) ? 1 : pr;
    endtask

    task automatic set_thr(input int c, input int t);
        wr(ctx_a(c, 'h04), t);
        m_thr[c] = t;
    endtask

    task automatic pulse(input logic [NS-1:0] m);
        @(negedge clk);
        src = src | m;
        @(negedge clk);
        src = src & ~m;
        for (int s = 1; s <= NS; s++)
            if (m[s-1] && m_en[s] && m_edge[s]) m_pend[s] = 1;
    endtask

    task automatic claim(input int c, input string req);
        logic [31:0] d;
        int e = exp_top(c);
        rd(ctx_a(c, 'h1C), d);
        chk(req, d, e);
        if ((e >> 16) != 0 && m_edge[e >> 16]) m_pend[e >> 16] = 0;
    endtask

    task automatic drain(input int c);
        for (int i = 0; i < NS + 1; i++) claim(c, "R8_drain");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int s = 1; s <= NS; s++) begin
            m_en[s] = 0; m_edge[s] = 0; m_pend[s] = 0; m_idx[s] = 0; m_prio[s] = 1;
        end
        for (int c = 0; c < NC; c++) m_thr[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk("R1_irq", {30'b0, irq_o}, 0);
        for (int c = 0; c < NC; c++) begin
            rd(ctx_a(c, 'h00), d); chk("R1_deliver", d, 0);
            chk("R12_ack", {31'b0, bus_ack}, 1);
            rd(ctx_a(c, 'h04), d); chk("R1_thresh", d, 0);
            rd(ctx_a(c, 'h1C), d); chk("R1_claim", d, 0);
        end
        for (int s = 1; s <= NS; s++) begin
            rd(tgt_a(s), d); chk("R1_target", d, 32'h1);
        end

        // R2 field layout and priority 0 -> 1
        wr(tgt_a(3), (5 << 18) | 0);
        rd(tgt_a(3), d); chk("R2_prio0", d, (5 << 18) | 1);
        wr(tgt_a(4), (1 << 18) | 8'hA7);
        rd(tgt_a(4), d); chk("R2_fields", d, (1 << 18) | 8'hA7);

        // R3 unimplemented target
        wr(tgt_a(NS + 1), 32'hFFFF_FFFF);
        rd(tgt_a(NS + 1), d); chk("R3_read0", d, 0);
        rd(tgt_a(1), d); chk("R3_noalias", d, 1);

        // configure: edge, ctx = s%2, prio = s%3+1
        for (int s = 1; s <= NS; s++) begin
            set_cfg(s, 1, 1);
            set_tgt(s, s % 2, (s % 3) + 1);
        end
        wr(ctx_a(0, 0), 1); wr(ctx_a(1, 0), 1);

        // single-source sweep (R7, R8, R10)
        for (int s = 1; s <= NS; s++) begin
            pulse(1 << (s - 1));
            chk("R10_irq_route", {30'b0, irq_o}, 1 << (s % 2));
            rd(ctx_a(s % 2, 'h18), d); chk("R7_top", d, exp_top(s % 2));
            claim(s % 2, "R7_claim");
            claim(s % 2, "R8_empty");
            chk("R10_irq_drop", {30'b0, irq_o}, 0);
        end

        // all pending: order by priority then ID (R7)
        pulse('1);
        for (int c = 0; c < NC; c++) drain(c);

        // threshold sweep on ctx1 (R9)
        for (int t = 0; t <= 4; t++) begin
            pulse('1);
            set_thr(1, t);
            rd(ctx_a(1, 'h18), d); chk("R9_thresh", d, exp_top(1));
            rd(ctx_a(0, 'h18), d); chk("R9_other_ctx", d, exp_top(0));
            set_thr(1, 0);
            drain(0); drain(1);
        end

        // delivery disabled (R10)
        wr(ctx_a(0, 0), 0);
        pulse(1 << 1);
        chk("R10_no_deliver", {30'b0, irq_o}, 0);
        rd(ctx_a(0, 'h18), d); chk("R10_top_indep", d, exp_top(0));
        wr(ctx_a(0, 0), 1);
        chk("R10_deliver_on", {30'b0, irq_o}, 1);
        drain(0);

        // disabled source (R6)
        set_cfg(4, 0, 1);
        pulse(1 << 3);
        chk("R6_irq", {30'b0, irq_o}, 0);
        rd(ctx_a(0, 'h18), d); chk("R6_top", d, 0);
        set_cfg(4, 1, 1);
        rd(ctx_a(0, 'h18), d); chk("R6_reenable", d, 0);

        // level source (R5)
        set_cfg(6, 1, 0);
        @(negedge clk); src[5] = 1;
        @(negedge clk);
        rd(ctx_a(0, 'h18), d); chk("R5_level_top", d, (6 << 16) | m_prio[6]);
        claim(0, "R5_claim1");
        claim(0, "R5_claim2");
        @(negedge clk); src[5] = 0;
        @(negedge clk);
        claim(0, "R5_gone");
        set_cfg(6, 1, 1);

        // edge held high (R4)
        @(negedge clk); src[1] = 1; m_pend[2] = 1;
        repeat (3) @(negedge clk);
        claim(0, "R4_once");
        claim(0, "R4_no_repeat");
        @(negedge clk); src[1] = 0;

        // out-of-range index (R11)
        set_tgt(7, 3, 1);
        pulse(1 << 6);
        chk("R11_irq", {30'b0, irq_o}, 0);
        rd(ctx_a(0, 'h18), d); chk("R11_ctx0", d, 0);
        rd(ctx_a(1, 'h18), d); chk("R11_ctx1", d, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule